// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous burst memory with a 32-bit data path split into four byte lanes. The rising clock edge captures the address, the three chip selects, the two address strobes, the advance input and the write controls. A transfer is opened by one of two strobes. The processor-side strobe always opens a read. The controller-side strobe opens either a read or a write, as the write controls decide. After that, the transfer continues through an internal two-bit burst counter, which counts in linear or interleaved order.

Reads go through one output register, so the data word appears one clock after its address is captured. Writes take effect at the edge that captures them. They cover any set of byte lanes, and a global write forces all four lanes. The data bus is driven only while a drive-enable output is high. That output is gated asynchronously by the output enable and by a snooze input, and it drops one cycle after a deselect or a write. Depth is a parameter and is kept small for simulation.

Top module: `pipe_burst_sram`

## Requirements
- R1: While reset is held and after reset is released, `dout_en` is low until a read has been issued.
- R2: The device is selected only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. The processor strobe `strobe_p_n` has no effect while `cs1_n`=1. A processor strobe taken with `cs1_n`=0 while `cs2_n`=1 or `cs3`=0 deselects the device, and `dout_en` is low after the second following edge.
- R3: `strobe_p_n`=0 with the device selected loads `addr` and starts a read, even when the write controls request a write. The word appears on `dout` after the next edge, with `dout_en` high.
- R4: `strobe_c_n`=0 with the device selected loads `addr` and starts a write if the write decode is true, otherwise a read. With any chip select inactive it deselects the device, and `dout_en` is low after the second following edge.
- R5: With both strobes high, `adv_n`=0 steps the burst counter n. The upper address bits stay fixed. When `seq_linear`=1 the low two bits are (start+n) mod 4. When `seq_linear`=0 they are start XOR n.
- R6: With both strobes high, `adv_n`=1 reuses the current address. A read at that point returns the same word again.
- R7: `wr_all_n`=0 writes all four lanes, whatever `lane_gate_n` and `lane_we_n` are.
- R8: `lane_we_n[k]`=0 writes lane k (bits 8k+7:8k) only when `lane_gate_n`=0. If `lane_gate_n`=1 and `wr_all_n`=1, the cycle is a read and memory is unchanged.
- R9: A cycle with both strobes high, `adv_n`=1 and a write request, following a processor-strobe read, writes the address that was just read.
- R10: `oe_n`=1 clears `dout_en` without waiting for a clock. A write cycle leaves `dout_en` low after the second following edge.
- R11: `snooze`=1 clears `dout_en` without waiting for a clock. Any strobe or write sampled while `snooze`=1 is ignored, and the device ends up deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| cs1_n | input | 1 | Select 1, active low, also gates the processor strobe |
| cs2_n | input | 1 | Select 2, active low |
| cs3 | input | 1 | Select 3, active high |
| strobe_p_n | input | 1 | Processor-side address strobe, active low |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| lane_gate_n | input | 1 | Gate for the lane enables, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| snooze | input | 1 | Standby request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data from the output register |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The assertions watch the output drive on every cycle. They check that snooze and the output enable always hold it off, that a deselect or a write turns it off two edges later, and that a processor-strobe read turns it on two edges later. Data content cannot be seen by a property without a memory model. So the burst orders, suspension, lane masking, the global-write override, write-after-read at the same address and the lost writes under snooze are shown only by the bench's scenarios, which compare every read word against a model built from the requirements.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } pbs_op_e;

  // low address bits of burst step cnt from start base
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input logic               linear
  );
    if (linear) return base + cnt;
    else        return base ^ cnt;
  endfunction
endpackage

// File: rtl/pbs_rst_sync.sv
module pbs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             cs1_n,
  input  logic             cs2_n,
  input  logic             cs3,
  input  logic             strobe_p_n,
  input  logic             strobe_c_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             lane_gate_n,
  input  logic             wr_all_n,
  input  logic             seq_linear,
  input  logic             snooze,
  output logic             wr_en,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_req,
  output logic [AW-1:0]    acc_addr
);
  localparam int HI_W = AW - BURST_W;

  logic               active_q, active_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic [BURST_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               sel, wr_req, p_hit, c_hit, load, cont;
  logic [BURST_W-1:0] cnt_step;
  pbs_op_e            op;

  always_comb begin
    sel      = !cs1_n && !cs2_n && cs3;
    wr_req   = !wr_all_n || (!lane_gate_n && (lane_we_n != '1));
    p_hit    = !snooze && !strobe_p_n && !cs1_n;
    c_hit    = !snooze && !p_hit && !strobe_c_n;
    load     = (p_hit || c_hit) && sel;
    cont     = !snooze && !(p_hit || c_hit) && active_q;
    cnt_step = adv_n ? cnt_q : cnt_q + 1'b1;

    if (load) acc_addr = addr;
    else      acc_addr = {hi_q, burst_low(base_q, cnt_step, seq_linear)};

    if (load)      op = (p_hit || !wr_req) ? OP_READ : OP_WRITE;
    else if (cont) op = wr_req ? OP_WRITE : OP_READ;
    else           op = OP_IDLE;

    if (!wr_all_n)        wr_mask = '1;
    else if (!lane_gate_n) wr_mask = ~lane_we_n;
    else                  wr_mask = '0;

    wr_en  = (op == OP_WRITE);
    rd_req = (op == OP_READ);

    active_d = load || cont;
    hi_d     = hi_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    if (load) begin
      hi_d   = addr[AW-1:BURST_W];
      base_d = addr[BURST_W-1:0];
      cnt_d  = '0;
    end else if (cont) begin
      cnt_d  = cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (load || cont) begin
        hi_q   <= hi_d;
        base_q <= base_d;
        cnt_q  <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/pbs_outpipe.sv
module pbs_outpipe #(
  parameter int AW     = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [AW-1:0]     acc_addr,
  input  logic              oe_n,
  input  logic              snooze,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              pend_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;
  logic              drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      pend_q  <= rd_req;
      drive_q <= pend_q;
      if (rd_req) addr_q <= acc_addr;
      if (pend_q) data_q <= rd_data;
    end
  end

  assign rd_addr = addr_q;
  assign dout    = data_q;
  assign dout_en = drive_q && !oe_n && !snooze;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = $clog2(DEPTH),
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              lane_gate_n,
  input  logic              wr_all_n,
  input  logic              oe_n,
  input  logic              seq_linear,
  input  logic              snooze,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              rst_sn;
  logic              wr_en, rd_req;
  logic [LANES-1:0]  wr_mask;
  logic [AW-1:0]     acc_addr, rd_addr;
  logic [DATA_W-1:0] rd_data;

  pbs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  pbs_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sn),
    .addr        (addr),
    .cs1_n       (cs1_n),
    .cs2_n       (cs2_n),
    .cs3         (cs3),
    .strobe_p_n  (strobe_p_n),
    .strobe_c_n  (strobe_c_n),
    .adv_n       (adv_n),
    .lane_we_n   (lane_we_n),
    .lane_gate_n (lane_gate_n),
    .wr_all_n    (wr_all_n),
    .seq_linear  (seq_linear),
    .snooze      (snooze),
    .wr_en       (wr_en),
    .wr_mask     (wr_mask),
    .rd_req      (rd_req),
    .acc_addr    (acc_addr)
  );

  pbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_mask (wr_mask),
    .wr_addr (acc_addr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  pbs_outpipe #(.AW(AW), .DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sn),
    .rd_req   (rd_req),
    .acc_addr (acc_addr),
    .oe_n     (oe_n),
    .snooze   (snooze),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .dout     (dout),
    .dout_en  (dout_en)
  );
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs1_n,
  input logic             cs2_n,
  input logic             cs3,
  input logic             strobe_p_n,
  input logic             strobe_c_n,
  input logic [LANES-1:0] lane_we_n,
  input logic             lane_gate_n,
  input logic             wr_all_n,
  input logic             oe_n,
  input logic             snooze,
  input logic             dout_en
);
  logic sel_c, p_go, wr_c;
  assign sel_c = !cs1_n && !cs2_n && cs3;
  assign p_go  = !snooze && !strobe_p_n && !cs1_n;
  assign wr_c  = !wr_all_n || (!lane_gate_n && (lane_we_n != '1));

  p_snooze_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !dout_en);

  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !p_go && !strobe_c_n && sel_c && wr_c) |=> ##1 !dout_en);

  p_desel_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !p_go && !strobe_c_n && !sel_c) |=> ##1 !dout_en);

  p_desel_p_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (p_go && !sel_c) |=> ##1 !dout_en);

  p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_go && sel_c) |=> ##1 (dout_en == (!oe_n && !snooze)));
endmodule

bind pipe_burst_sram pbs_checker #(.LANES(LANES)) u_pbs_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .cs1_n       (cs1_n),
  .cs2_n       (cs2_n),
  .cs3         (cs3),
  .strobe_p_n  (strobe_p_n),
  .strobe_c_n  (strobe_c_n),
  .lane_we_n   (lane_we_n),
  .lane_gate_n (lane_gate_n),
  .wr_all_n    (wr_all_n),
  .oe_n        (oe_n),
  .snooze      (snooze),
  .dout_en     (dout_en)
);

// File: tb/test_pipe_burst_sram.sv
`timescale 1ns/1ps
module test_pipe_burst_sram;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr;
  logic        cs1_n, cs2_n, cs3, strobe_p_n, strobe_c_n, adv_n;
  logic [3:0]  lane_we_n;
  logic        lane_gate_n, wr_all_n, oe_n, seq_linear, snooze;
  logic [31:0] din, dout;
  logic        dout_en;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [DEPTH];

  // {linear, start address, lane mask, global}
  localparam logic [11:0] VEC [8] = '{
    {1'b1, 6'd5,  4'hF, 1'b0},
    {1'b0, 6'd10, 4'h5, 1'b0},
    {1'b1, 6'd19, 4'h0, 1'b1},
    {1'b0, 6'd23, 4'h8, 1'b0},
    {1'b1, 6'd34, 4'h3, 1'b0},
    {1'b0, 6'd45, 4'h0, 1'b1},
    {1'b1, 6'd62, 4'hC, 1'b0},
    {1'b0, 6'd0,  4'h1, 1'b0}
  };

  always #2.5 clk = ~clk;

  pipe_burst_sram i_pipe_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .cs3(cs3), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .adv_n(adv_n), .lane_we_n(lane_we_n), .lane_gate_n(lane_gate_n),
    .wr_all_n(wr_all_n), .oe_n(oe_n), .seq_linear(seq_linear),
    .snooze(snooze), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkdata(int i, int b);
    return {8'(8'h30 + i), 8'(8'h50 + b), 8'(8'h70 + i + b), 8'(8'h90 ^ (i * 4 + b))};
  endfunction

  function automatic int blk(int s, int i, bit lin);
    return (s & ~3) | (lin ? ((s + i) & 3) : (((s & 3) ^ i) & 3));
  endfunction

  task automatic mdl_w(int a, logic [31:0] d, logic [3:0] m, bit g);
    for (int l = 0; l < 4; l++)
      if (g || m[l]) mdl[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic drv_base();
    cs1_n = 0; cs2_n = 0; cs3 = 1; strobe_p_n = 1; strobe_c_n = 1; adv_n = 1;
    lane_we_n = 4'hF; lane_gate_n = 1; wr_all_n = 1;
  endtask

  task automatic go_idle();
    drv_base(); cs1_n = 1; strobe_c_n = 0; step();
  endtask

  task automatic op_pread(int a, bit wrjunk);
    drv_base(); strobe_p_n = 0; addr = 6'(a);
    if (wrjunk) begin wr_all_n = 0; lane_gate_n = 0; lane_we_n = 4'h0; end
    step();
  endtask

  task automatic set_wr(bit w, logic [31:0] d, logic [3:0] m, bit g);
    din = d;
    if (w) begin lane_gate_n = 0; lane_we_n = ~m; wr_all_n = !g; end
  endtask

  task automatic op_cstart(int a, bit w, logic [31:0] d, logic [3:0] m, bit g);
    drv_base(); strobe_c_n = 0; addr = 6'(a); set_wr(w, d, m, g); step();
  endtask

  task automatic op_cont(bit adv, bit w, logic [31:0] d, logic [3:0] m, bit g);
    drv_base(); adv_n = !adv; set_wr(w, d, m, g); step();
  endtask

  initial begin
    rst_n = 0; drv_base(); cs1_n = 1; strobe_c_n = 0;
    addr = '0; din = '0; oe_n = 0; seq_linear = 1; snooze = 0;
    repeat (3) step();
    check("R1 drive low in reset", {31'b0, dout_en}, 32'd0);
    rst_n = 1;
    repeat (3) step();
    check("R1 drive low after reset", {31'b0, dout_en}, 32'd0);

    // fill memory: global-write linear bursts
    seq_linear = 1;
    for (int k = 0; k < DEPTH / 4; k++) begin
      op_cstart(4 * k, 1, 32'hC0DE_0000 + 32'(4 * k), 4'h0, 1);
      mdl_w(4 * k, 32'hC0DE_0000 + 32'(4 * k), 4'h0, 1);
      for (int b = 1; b < 4; b++) begin
        op_cont(1, 1, 32'hC0DE_0000 + 32'(4 * k + b), 4'h0, 1);
        mdl_w(4 * k + b, 32'hC0DE_0000 + 32'(4 * k + b), 4'h0, 1);
      end
    end
    go_idle();

    // vector table: masked burst write then burst read (R4 R5 R7 R8 R3)
    for (int i = 0; i < 8; i++) begin
      automatic logic [11:0] v = VEC[i];
      automatic bit lin = v[11];
      automatic int s = int'(v[10:5]);
      automatic logic [3:0] m = v[4:1];
      automatic bit g = v[0];
      seq_linear = lin;
      op_cstart(s, 1, mkdata(i, 0), m, g);
      mdl_w(blk(s, 0, lin), mkdata(i, 0), m, g);
      for (int b = 1; b < 4; b++) begin
        op_cont(1, 1, mkdata(i, b), m, g);
        mdl_w(blk(s, b, lin), mkdata(i, b), m, g);
      end
      go_idle();
      op_pread(s, 1);
      for (int b = 1; b < 4; b++) begin
        op_cont(1, 0, 32'h0, 4'h0, 0);
        check("R5 R7 R8 R3 burst read data", dout, mdl[blk(s, b - 1, lin)]);
        check("R3 read drive", {31'b0, dout_en}, 32'd1);
      end
      go_idle();
      check("R5 last beat data", dout, mdl[blk(s, 3, lin)]);
      go_idle();
      check("R4 deselect drops drive", {31'b0, dout_en}, 32'd0);
    end

    // R6 suspend
    seq_linear = 1;
    op_pread(8, 0);
    op_cont(1, 0, 0, 0, 0); check("R6 beat 8", dout, mdl[8]);
    op_cont(0, 0, 0, 0, 0); check("R6 beat 9", dout, mdl[9]);
    op_cont(1, 0, 0, 0, 0); check("R6 suspended repeat 9", dout, mdl[9]);
    go_idle();              check("R6 resumed 10", dout, mdl[10]);
    go_idle();

    // R9 write after processor read at same address
    op_pread(40, 0);
    op_cont(0, 1, 32'hA1B2_C3D4, 4'h0, 1);
    check("R9 read before write", dout, mdl[40]);
    mdl_w(40, 32'hA1B2_C3D4, 4'h0, 1);
    go_idle();
    op_pread(40, 0); go_idle();
    check("R9 written at read address", dout, 32'hA1B2_C3D4);
    go_idle();

    // R8 gate high: lane enables ignored, cycle is a read
    op_cstart(41, 0, 32'h0, 4'h0, 0);
    drv_base(); strobe_c_n = 0; addr = 6'd42; din = 32'hFFFF_FFFF;
    lane_gate_n = 1; lane_we_n = 4'h0; wr_all_n = 1; step();
    check("R8 ungated read 41", dout, mdl[41]);
    go_idle();
    check("R8 no write, read 42", dout, mdl[42]);
    check("R8 read drives", {31'b0, dout_en}, 32'd1);
    go_idle();

    // R2 processor strobe ignored with cs1_n high
    op_pread(12, 0);
    drv_base(); cs1_n = 1; strobe_p_n = 0; adv_n = 0; addr = 6'd50; step();
    check("R2 first word", dout, mdl[12]);
    go_idle();
    check("R2 strobe ignored, burst advanced", dout, mdl[13]);
    go_idle();

    // R2 processor strobe with cs3 low deselects
    op_pread(20, 0);
    drv_base(); strobe_p_n = 0; cs3 = 0; step();
    check("R2 word before deselect", dout, mdl[20]);
    drv_base(); adv_n = 0; step();
    check("R2 processor-strobe deselect", {31'b0, dout_en}, 32'd0);
    go_idle();

    // R10 asynchronous output enable
    op_pread(30, 0); go_idle();
    check("R10 drive on", {31'b0, dout_en}, 32'd1);
    oe_n = 1; #0.5;
    check("R10 oe_n high clears drive", {31'b0, dout_en}, 32'd0);
    oe_n = 0; #0.5;
    check("R10 oe_n low restores drive", {31'b0, dout_en}, 32'd1);
    go_idle();

    // R11 snooze
    op_pread(31, 0); go_idle();
    snooze = 1; #0.5;
    check("R11 snooze clears drive", {31'b0, dout_en}, 32'd0);
    op_cstart(31, 1, 32'hDEAD_BEEF, 4'h0, 1);
    snooze = 0;
    go_idle();
    op_pread(31, 0); go_idle();
    check("R11 write during snooze ignored", dout, mdl[31]);
    go_idle();

    // R10 write cycle turns drive off
    op_pread(32, 0);
    op_cstart(33, 1, 32'h5566_7788, 4'h0, 1);
    mdl_w(33, 32'h5566_7788, 4'h0, 1);
    check("R10 read before write", dout, mdl[32]);
    drv_base(); step();
    check("R10 write leaves drive off", {31'b0, dout_en}, 32'd0);
    go_idle();
    op_pread(33, 0); go_idle();
    check("R4 controller-strobe write stored", dout, 32'h5566_7788);
    go_idle();

    summary();
    $finish;
  end
endmodule